// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the master side of the two-wire PHY management interface. A host gives it a 5-bit PHY address, a 5-bit register address, a read/write flag and, for writes, a 16-bit value, then pulses `start` for one clock. The master makes the management clock (MDC) and drives or releases the data line (MDIO). It sends a long run of ones as preamble, then the frame header and the turnaround. It then shifts 16 data bits out, or samples 16 bits in. The frame goes out MSB first.

Each bit takes one slot. A slot is a low half-period of MDC followed by a high half-period. The parameter `HALF_CLKS` gives the length of each half in system clocks. Outgoing bits change only at the start of a slot, while MDC is low. For a read, the master releases MDIO after the register address. It gives one turnaround pulse, then 16 data pulses and one trailing pulse. Each bit is sampled one half-period after MDC falls, through a two-flop synchronizer. For a write, the master drives turnaround 1,0 and the 16 data bits. It then releases MDIO for one trailing pulse.

The control path is one state machine with these states:
- `S_IDLE`: waits for `start`, and goes to `S_PRE` when it comes.
- `S_PRE`: sends the preamble ones and goes to `S_HDR` after the last one.
- `S_HDR`: sends start-of-frame, opcode and both addresses. It then goes to `S_RTA` for a read or `S_WTA` for a write.
- `S_WTA` goes to `S_WDAT`, and `S_WDAT` goes to `S_TAIL`.
- `S_RTA` goes to `S_RDAT`, and `S_RDAT` goes to `S_TAIL`.
- `S_TAIL` goes back to `S_IDLE` and raises `done`.

Top module: `mdio_master`

## Requirements
- R1: Out of reset and whenever idle: `mdc` = 0, `mdio_oe` = 0, `busy` = 0, `done` = 0. After reset, `rd_data` = 0.
- R2: A transaction first drives 40 MDC pulses with `mdio_oe` = 1 and `mdio_o` = 1 (pulses 0..39).
- R3: Pulses 40,41 carry start-of-frame 0,1. Pulses 42,43 carry the opcode: 1,0 for a read (`rd_req`=1) and 0,1 for a write.
- R4: Pulses 44..48 carry `phy_addr` MSB first, and pulses 49..53 carry `reg_addr` MSB first, all driven.
- R5: Every MDC half-period lasts `HALF_CLKS` clocks, and a driven `mdio_o` changes only while `mdc` is low.
- R6: A read releases MDIO (`mdio_oe` = 0) for pulses 54..71, which is 18 pulses: turnaround, 16 data and one trailing. The frame has 72 pulses. Bit k of the read data is sampled while `mdc` is low, one half-period after the falling edge of the pulse that follows the PHY placing bit 15-k on the line. Sampling goes through a two-flop synchronizer.
- R7: A write drives turnaround 1,0 on pulses 54,55 and `wr_data` MSB first on pulses 56..71. It then gives pulse 72 with MDIO released. The frame has 73 pulses.
- R8: `busy` rises the clock after an accepted `start`. It stays high for exactly (pulses × 2 × `HALF_CLKS`) clocks, and falls in the same clock that the one-cycle `done` pulse rises.
- R9: `start` while `busy` is ignored: the running frame is unchanged and no second frame follows.
- R10: After a read, `rd_data` holds the 16 sampled bits when `done` rises. A write leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-clock request to begin a frame |
| rd_req | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Value to write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock pulse at frame end |
| rd_data | output | 16 | Data from the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line input |

## Verification
Some rules are checked on every cycle by the assertions:
- the line is quiet while idle;
- the driven data changes only while MDC is low;
- sampling happens only in a low half;
- the half-period counter stays in range;
- `done` is a single pulse that coincides with `busy` falling.

Other behaviour can only be shown by the bench scenarios, against a behavioural PHY. These are the bit order and content of each field, the pulse counts of read and write frames, the exact busy length, the value assembled from a read, and that a `start` during a frame neither corrupts it nor starts another.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_HDR,
        S_WTA,
        S_WDAT,
        S_RTA,
        S_RDAT,
        S_TAIL
    } mst_state_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_CLKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic low_end,
    output logic slot_end
);
    localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

    logic [CW-1:0] cnt_q;
    logic          half_q;
    logic          tick;

    assign tick = run && (cnt_q == CW'(HALF_CLKS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q  <= '0;
            half_q <= 1'b0;
        end else if (tick) begin
            cnt_q  <= '0;
            half_q <= ~half_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc      = half_q;
    assign low_end  = tick & ~half_q;
    assign slot_end = tick & half_q;

    AST_HALF_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < HALF_CLKS); // R5
    AST_MDC_LOW_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc); // R1
endmodule

// File: rtl/mdio_sync.sv
module mdio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sh_q <= '1;
                else        sh_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) sh_q <= '1;
                else        sh_q <= {sh_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_CLKS = 100,
    parameter int PRE_LEN   = 40,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int HDR_W = 4 + 2 * ADDR_W;
    localparam int CNT_W = $clog2(PRE_LEN + HDR_W + DATA_W + 1);

    mst_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [HDR_W-1:0]  hdr_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] rd_shift_q;
    logic [DATA_W-1:0] rd_data_q;
    logic              is_rd_q;
    logic              done_q;
    logic              low_end, slot_end;
    logic              mdio_s;
    logic              last_bit;
    logic              sample_en;

    mdio_mdc_gen #(.HALF_CLKS(HALF_CLKS)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q != S_IDLE),
        .mdc      (mdc),
        .low_end  (low_end),
        .slot_end (slot_end)
    );

    mdio_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (mdio_i),
        .q     (mdio_s)
    );

    always_comb begin
        last_bit = 1'b0;
        unique case (state_q)
            S_IDLE:         last_bit = 1'b0;
            S_PRE:          last_bit = (cnt_q == CNT_W'(PRE_LEN - 1));
            S_HDR:          last_bit = (cnt_q == CNT_W'(HDR_W - 1));
            S_WTA:          last_bit = (cnt_q == CNT_W'(1));
            S_WDAT, S_RDAT: last_bit = (cnt_q == CNT_W'(DATA_W - 1));
            S_RTA, S_TAIL:  last_bit = 1'b1;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_PRE;
            S_PRE:  if (slot_end && last_bit) state_d = S_HDR;
            S_HDR:  if (slot_end && last_bit) state_d = is_rd_q ? S_RTA : S_WTA;
            S_WTA:  if (slot_end && last_bit) state_d = S_WDAT;
            S_WDAT: if (slot_end && last_bit) state_d = S_TAIL;
            S_RTA:  if (slot_end && last_bit) state_d = S_RDAT;
            S_RDAT: if (slot_end && last_bit) state_d = S_TAIL;
            S_TAIL: if (slot_end && last_bit) state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    assign sample_en = low_end &&
        ((state_q == S_RDAT && cnt_q != '0) || (state_q == S_TAIL && is_rd_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            hdr_q      <= '0;
            wd_q       <= '0;
            rd_shift_q <= '0;
            rd_data_q  <= '0;
            is_rd_q    <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == S_IDLE && start) begin
                hdr_q   <= {2'b01, (rd_req ? 2'b10 : 2'b01), phy_addr, reg_addr};
                wd_q    <= wr_data;
                is_rd_q <= rd_req;
                cnt_q   <= '0;
            end else if (slot_end) begin
                cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
                if (state_q == S_HDR)  hdr_q <= {hdr_q[HDR_W-2:0], 1'b0};
                if (state_q == S_WDAT) wd_q  <= {wd_q[DATA_W-2:0], 1'b0};
                if (state_q == S_TAIL) begin
                    done_q <= 1'b1;
                    if (is_rd_q) rd_data_q <= rd_shift_q;
                end
            end
            if (sample_en) rd_shift_q <= {rd_shift_q[DATA_W-2:0], mdio_s};
        end
    end

    always_comb begin
        busy    = (state_q != S_IDLE);
        done    = done_q;
        rd_data = rd_data_q;
        mdio_oe = 1'b0;
        mdio_o  = 1'b0;
        unique case (state_q)
            S_PRE:  begin mdio_oe = 1'b1; mdio_o = 1'b1;             end
            S_HDR:  begin mdio_oe = 1'b1; mdio_o = hdr_q[HDR_W-1];   end
            S_WTA:  begin mdio_oe = 1'b1; mdio_o = (cnt_q == '0);    end
            S_WDAT: begin mdio_oe = 1'b1; mdio_o = wd_q[DATA_W-1];   end
            S_IDLE, S_RTA, S_RDAT, S_TAIL: begin mdio_oe = 1'b0; mdio_o = 1'b0; end
        endcase
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe)); // R1
    AST_DATA_SETUP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && !$stable(mdio_o)) |-> !mdc); // R5
    AST_SAMPLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> !mdc); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(is_rd_q)); // R9
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        rd_req;
    logic [4:0]  phy_addr, reg_addr;
    logic [15:0] wr_data;
    logic        busy, done, mdc, mdio_o, mdio_oe, mdio_i;
    logic [15:0] rd_data;

    logic        phy_oe, phy_o;
    logic [15:0] phy_val;
    logic        rec_o  [0:127];
    logic        rec_oe [0:127];
    int          npulse, hi_clks;
    int          n_chk = 0, n_err = 0;
    bit          finished = 0;

    always #5 clk = ~clk;

    mdio_master #(.HALF_CLKS(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    assign mdio_i = phy_oe ? phy_o : (mdio_oe ? mdio_o : 1'b1);

    // recorder and behavioural PHY: acts on each MDC rising edge
    always @(posedge mdc) begin
        if (npulse < 128) begin
            rec_o[npulse]  = mdio_o;
            rec_oe[npulse] = mdio_oe;
        end
        if (npulse >= 54 && rec_o[42] && !rec_o[43]) begin
            if (npulse == 54) begin
                phy_oe = 1'b1; phy_o = 1'b0;
            end else if (npulse >= 55 && npulse <= 70) begin
                phy_o = phy_val[70 - npulse];
            end else if (npulse == 71) begin
                phy_oe = 1'b0;
            end
        end
        npulse++;
    end

    always @(negedge clk) if (mdc) hi_clks++;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // runs one frame; optional start pulse during busy
    task automatic run_frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input bit inject, output int cyc);
        @(negedge clk);
        rd_req = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
        npulse = 0; hi_clks = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy) begin
            cyc++;
            if (inject && cyc == 100) begin
                start = 1'b1; rd_req = ~rd; phy_addr = ~pa; wr_data = ~wd;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk("R8", "done at busy fall", {31'd0, done}, 32'd1);
        @(negedge clk);
        chk("R8", "done one cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic check_header(input logic rd, input logic [4:0] pa, input logic [4:0] ra);
        int ones = 0;
        logic [3:0] so;
        logic [9:0] ad;
        int oe_cnt = 0;
        for (int i = 0; i < 40; i++) if (rec_o[i] && rec_oe[i]) ones++;
        chk("R2", "preamble ones", ones, 40);
        for (int i = 0; i < 4; i++) so[3-i] = rec_o[40+i];
        chk("R3", "sof+opcode", {28'd0, so}, {28'd0, 2'b01, (rd ? 2'b10 : 2'b01)});
        for (int i = 0; i < 10; i++) ad[9-i] = rec_o[44+i];
        for (int i = 40; i < 54; i++) if (rec_oe[i]) oe_cnt++;
        chk("R4", "phy+reg addr", {22'd0, ad}, {22'd0, pa, ra});
        chk("R4", "header driven", oe_cnt, 14);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start = 1'b0; rd_req = 1'b0; phy_addr = '0; reg_addr = '0;
        wr_data = '0; phy_oe = 1'b0; phy_o = 1'b0; phy_val = '0; npulse = 0; hi_clks = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle outputs", {28'd0, mdc, mdio_oe, busy, done}, 32'd0);
        chk("R1", "rd_data reset", {16'd0, rd_data}, 32'd0);
    endtask

    task automatic t_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
                           input bit inject);
        int cyc;
        logic [15:0] dv;
        logic [15:0] rd_before;
        rd_before = rd_data;
        run_frame(1'b0, pa, ra, wd, inject, cyc);
        check_header(1'b0, pa, ra);
        chk("R7", "turnaround", {30'd0, rec_o[54], rec_o[55]}, 32'd2);
        chk("R7", "turnaround driven", {30'd0, rec_oe[54], rec_oe[55]}, 32'd3);
        for (int i = 0; i < 16; i++) dv[15-i] = rec_o[56+i];
        chk("R7", "write data", {16'd0, dv}, {16'd0, wd});
        chk("R7", "trailing released", {31'd0, rec_oe[72]}, 32'd0);
        chk("R7", "pulse count", npulse, 73);
        chk("R5", "mdc high clocks", hi_clks, 73 * HALF);
        chk("R8", "busy length", cyc, 73 * 2 * HALF);
        chk("R10", "write keeps rd_data", {16'd0, rd_data}, {16'd0, rd_before});
        if (inject) begin
            repeat (4 * HALF) @(negedge clk);
            chk("R9", "no second frame", {30'd0, busy, mdc}, 32'd0);
            chk("R9", "no extra pulses", npulse, 73);
        end
    endtask

    task automatic t_read(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] val);
        int cyc;
        int oe_cnt = 0;
        phy_val = val;
        run_frame(1'b1, pa, ra, 16'h0, 1'b0, cyc);
        check_header(1'b1, pa, ra);
        for (int i = 54; i < 72; i++) if (rec_oe[i]) oe_cnt++;
        chk("R6", "released pulses", oe_cnt, 0);
        chk("R6", "pulse count", npulse, 72);
        chk("R5", "mdc high clocks", hi_clks, 72 * HALF);
        chk("R8", "busy length", cyc, 72 * 2 * HALF);
        chk("R10", "read data", {16'd0, rd_data}, {16'd0, val});
        chk("R1", "idle after read", {30'd0, mdc, mdio_oe}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL R8 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_write(5'h11, 5'h0A, 16'hBEEF, 1'b0);
        t_read(5'h1F, 5'h00, 16'hA5C3);
        t_read(5'h00, 5'h1F, 16'h8001);
        t_write(5'h03, 5'h15, 16'h0000, 1'b0);
        t_write(5'h0C, 5'h07, 16'h5AF0, 1'b1);
        t_read(5'h15, 5'h0A, 16'hFFFE);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule